// File: doc/BRIEF.md
# Control Panel Interrupt Controller

This block runs a second interrupt level that sits above the ordinary one. When a panel request is pending, it takes the processor into a separate panel memory space. It first stores the interrupted program counter at panel address zero, then loads the all-ones address as the new program counter and commands the processor to run. From then on, memory accesses go to panel memory and ordinary interrupts are held off.

Panel requests have four causes: power-on, a halt instruction, a software trap instruction and an external device request. Software reads which causes occurred from a sticky cause register and clears it with a read-and-clear strobe. The block also reports a priority code for the entry that was taken. It watches the retiring instruction stream for the exit sequence: an interrupt-enable instruction followed directly by an indirect jump through location zero. When the jump retires, the block restores the run or halt state that was saved at entry and switches accesses back to main memory.

The sequencer has six states:
- MAIN: normal operation.
- SAVE: the PC is written to panel address 0.
- VECTOR: the PC is loaded with all ones and a run command is issued.
- PANEL: panel code executes.
- ARMED: an interrupt-enable instruction has just retired in panel mode.
- LEAVE: the run state is restored and accesses return to main memory.

The transitions are:
- take: MAIN to SAVE.
- stored: SAVE to VECTOR.
- vectored: VECTOR to PANEL.
- arm: PANEL to ARMED, or ARMED to ARMED.
- disarm: ARMED to PANEL on any other instruction.
- exit: ARMED to LEAVE on the jump.
- done: LEAVE to MAIN.

Top module: `pcp_ctrl`

## Requirements
- R1: The power-on cause (cause bit 0) is set by reset. The first accepted entry after reset has entry code 0 and takes place without any retiring instruction.
- R2: In MAIN with a request pending, entry is taken at the next clock edge at which either `instr_done` is high or `cpu_running` is low. While running with no retiring instruction, the block stays in main memory.
- R3: Entry sequence, one cycle per step:
  - the cycle after acceptance: `save_we` is high, `save_addr` is 0 and `save_data` is the PC sampled at acceptance;
  - the next cycle: `pc_load_en` is high with `pc_load_val` all ones, together with `run_ctl_valid` and `run_ctl_value` = 1;
  - after that, `panel_mode` is high.
- R4: `space_panel` is high from the save cycle through the last panel cycle and is low in MAIN and LEAVE.
- R5: `irq_block` is high whenever `panel_mode` is high.
- R6: Exit is the retirement of an interrupt-enable instruction followed directly by the retirement of an indirect jump through location 0. In the cycle after the jump retires, `run_ctl_valid` is high with `run_ctl_value` equal to the `cpu_running` value sampled at acceptance, and `space_panel` is low. Any other instruction retiring between the two cancels the sequence.
- R7: The cause bits are bit 0 power-on, bit 1 halt instruction, bit 2 trap instruction and bit 3 device request. They are sticky. A `cause_clr` pulse clears all of them, and a request arriving in the same cycle as the clear still sets its bit.
- R8: A request that arrives in panel mode causes no re-entry. It stays pending and is serviced at the first qualifying edge after the exit.
- R9: `entry_code` gives the highest-priority cause pending at acceptance: 0 power-on, 1 halt, 2 trap, 3 device. Power-on ranks highest and device lowest.
- R10: While reset is held, the block is in MAIN and `cause_q` = 4'b0001.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; forces a power-on request |
| cpu_pc | input | AW | Current program counter |
| cpu_running | input | 1 | 1 = processor running, 0 = halted |
| instr_done | input | 1 | An instruction retires this cycle |
| instr_is_ion | input | 1 | The retiring instruction is interrupt-enable |
| instr_is_jmpi0 | input | 1 | The retiring instruction is an indirect jump through location 0 |
| req_halt | input | 1 | Halt instruction request pulse |
| req_trap | input | 1 | Software trap instruction request pulse |
| req_device | input | 1 | External device request pulse |
| cause_clr | input | 1 | Read-and-clear strobe for the cause register |
| space_panel | output | 1 | 1 = accesses go to panel memory |
| save_we | output | 1 | Write strobe for storing the PC into panel memory |
| save_addr | output | AW | Address for the PC store (always 0) |
| save_data | output | AW | PC value to store |
| pc_load_en | output | 1 | Load the program counter |
| pc_load_val | output | AW | Program counter load value |
| run_ctl_valid | output | 1 | Run-state command valid |
| run_ctl_value | output | 1 | Commanded run state |
| panel_mode | output | 1 | Panel code is executing |
| irq_block | output | 1 | Suppresses ordinary interrupts |
| cause_q | output | 4 | Sticky cause register |
| entry_code | output | 2 | Priority code of the last entry |

## Verification
The hardest situation to reach from the ports is a request that arrives while panel mode is already active and must be deferred past the exit. Reaching it requires a device entry, then a trap pulse inside panel code, then an exit sequence that is first broken by an intervening instruction and then completed. The monitor then confirms that no extra save or vector event appears until the deferred trap entry, and that this entry occurs only at the first retiring instruction after LEAVE. The priority path is driven by pulsing the halt and device requests in the same cycle while the processor is halted.

// File: rtl/pcp_pkg.sv
package pcp_pkg;
    localparam int NUM_CAUSE = 4;
    localparam int CODE_W    = 2;

    typedef enum logic [2:0] {
        ST_MAIN,
        ST_SAVE,
        ST_VECTOR,
        ST_PANEL,
        ST_ARMED,
        ST_LEAVE
    } pcp_state_e;
endpackage

// File: rtl/pcp_cause_unit.sv
module pcp_cause_unit #(
    parameter int NC = 4,
    localparam int CW = (NC > 1) ? $clog2(NC) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NC-1:0] req_vec,
    input  logic          take,
    input  logic          clr,
    output logic [NC-1:0] cause_q,
    output logic [NC-1:0] pend_q,
    output logic [CW-1:0] top_code,
    output logic          any_pend
);
    localparam logic [NC-1:0] PWR_ONLY = NC'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cause_q <= PWR_ONLY;
            pend_q  <= PWR_ONLY;
        end else begin
            cause_q <= (clr ? '0 : cause_q) | req_vec;
            pend_q  <= (take ? '0 : pend_q) | req_vec;
        end
    end

    always_comb begin
        top_code = '0;
        for (int i = NC - 1; i >= 0; i--) begin
            if (pend_q[i]) top_code = CW'(i);
        end
    end

    assign any_pend = |pend_q;

    // R7: a set bit survives unless the clear strobe was present
    a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(clr) |-> ((cause_q & $past(cause_q)) == $past(cause_q)));

    // R8: after an entry only the requests of that cycle remain pending
    a_r8_consume: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> (pend_q == $past(req_vec)));
endmodule

// File: rtl/pcp_seq_fsm.sv
module pcp_seq_fsm
    import pcp_pkg::*;
#(
    parameter int AW = 12,
    parameter int CW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          any_pend,
    input  logic [CW-1:0] top_code,
    input  logic [AW-1:0] cpu_pc,
    input  logic          cpu_running,
    input  logic          instr_done,
    input  logic          instr_is_ion,
    input  logic          instr_is_jmpi0,
    output logic          take,
    output logic          space_panel,
    output logic          save_we,
    output logic [AW-1:0] save_addr,
    output logic [AW-1:0] save_data,
    output logic          pc_load_en,
    output logic [AW-1:0] pc_load_val,
    output logic          run_ctl_valid,
    output logic          run_ctl_value,
    output logic          panel_mode,
    output logic          irq_block,
    output logic [CW-1:0] entry_code
);
    localparam logic [AW-1:0] SAVE_LOC  = '0;
    localparam logic [AW-1:0] ENTRY_LOC = '1;

    pcp_state_e    state_q, state_d;
    logic [AW-1:0] pc_hold_q;
    logic          run_hold_q;

    assign take = (state_q == ST_MAIN) && any_pend && (instr_done || !cpu_running);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_MAIN:   if (take) state_d = ST_SAVE;
            ST_SAVE:   state_d = ST_VECTOR;
            ST_VECTOR: state_d = ST_PANEL;
            ST_PANEL:  if (instr_done && instr_is_ion) state_d = ST_ARMED;
            ST_ARMED: begin
                if (instr_done) begin
                    if (instr_is_jmpi0)    state_d = ST_LEAVE;
                    else if (instr_is_ion) state_d = ST_ARMED;
                    else                   state_d = ST_PANEL;
                end
            end
            ST_LEAVE:  state_d = ST_MAIN;
            default:   state_d = ST_MAIN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= ST_MAIN;
            pc_hold_q  <= '0;
            run_hold_q <= 1'b0;
            entry_code <= '0;
        end else begin
            state_q <= state_d;
            if (take) begin
                pc_hold_q  <= cpu_pc;
                run_hold_q <= cpu_running;
                entry_code <= top_code;
            end
        end
    end

    always_comb begin
        space_panel   = 1'b0;
        save_we       = 1'b0;
        pc_load_en    = 1'b0;
        run_ctl_valid = 1'b0;
        run_ctl_value = 1'b0;
        panel_mode    = 1'b0;
        irq_block     = 1'b0;
        unique case (state_q)
            ST_MAIN: ;
            ST_SAVE: begin
                space_panel = 1'b1;
                save_we     = 1'b1;
                irq_block   = 1'b1;
            end
            ST_VECTOR: begin
                space_panel   = 1'b1;
                pc_load_en    = 1'b1;
                run_ctl_valid = 1'b1;
                run_ctl_value = 1'b1;
                irq_block     = 1'b1;
            end
            ST_PANEL, ST_ARMED: begin
                space_panel = 1'b1;
                panel_mode  = 1'b1;
                irq_block   = 1'b1;
            end
            ST_LEAVE: begin
                run_ctl_valid = 1'b1;
                run_ctl_value = run_hold_q;
            end
            default: ;
        endcase
    end

    assign save_addr   = SAVE_LOC;
    assign save_data   = pc_hold_q;
    assign pc_load_val = ENTRY_LOC;

    // R2: a save only follows a qualifying acceptance edge
    a_r2_enter_cond: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(save_we) |-> $past(any_pend) && ($past(instr_done) || !$past(cpu_running)));

    // R3: save is followed by the vector step, then panel mode
    a_r3_save_vector: assert property (@(posedge clk) disable iff (!rst_n)
        save_we |=> pc_load_en && run_ctl_value);
    a_r3_vector_panel: assert property (@(posedge clk) disable iff (!rst_n)
        pc_load_en |=> panel_mode);

    // R4: panel execution is always in panel space
    a_r4_space: assert property (@(posedge clk) disable iff (!rst_n)
        panel_mode |-> space_panel);

    // R5: ordinary interrupts are held off in panel mode
    a_r5_block: assert property (@(posedge clk) disable iff (!rst_n)
        panel_mode |-> irq_block);

    // R6: restore step lies in main space and follows panel execution
    a_r6_leave: assert property (@(posedge clk) disable iff (!rst_n)
        (run_ctl_valid && !pc_load_en) |-> !space_panel && $past(panel_mode));
endmodule

// File: rtl/pcp_ctrl.sv
module pcp_ctrl #(
    parameter int AW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] cpu_pc,
    input  logic          cpu_running,
    input  logic          instr_done,
    input  logic          instr_is_ion,
    input  logic          instr_is_jmpi0,
    input  logic          req_halt,
    input  logic          req_trap,
    input  logic          req_device,
    input  logic          cause_clr,
    output logic          space_panel,
    output logic          save_we,
    output logic [AW-1:0] save_addr,
    output logic [AW-1:0] save_data,
    output logic          pc_load_en,
    output logic [AW-1:0] pc_load_val,
    output logic          run_ctl_valid,
    output logic          run_ctl_value,
    output logic          panel_mode,
    output logic          irq_block,
    output logic [3:0]    cause_q,
    output logic [1:0]    entry_code
);
    import pcp_pkg::*;

    logic [NUM_CAUSE-1:0] req_vec;
    logic [NUM_CAUSE-1:0] pend_q;
    logic [CODE_W-1:0]    top_code;
    logic                 any_pend;
    logic                 take;

    assign req_vec = {req_device, req_trap, req_halt, 1'b0};

    pcp_cause_unit #(.NC(NUM_CAUSE)) u_cause (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_vec  (req_vec),
        .take     (take),
        .clr      (cause_clr),
        .cause_q  (cause_q),
        .pend_q   (pend_q),
        .top_code (top_code),
        .any_pend (any_pend)
    );

    pcp_seq_fsm #(.AW(AW), .CW(CODE_W)) u_seq (
        .clk            (clk),
        .rst_n          (rst_n),
        .any_pend       (any_pend),
        .top_code       (top_code),
        .cpu_pc         (cpu_pc),
        .cpu_running    (cpu_running),
        .instr_done     (instr_done),
        .instr_is_ion   (instr_is_ion),
        .instr_is_jmpi0 (instr_is_jmpi0),
        .take           (take),
        .space_panel    (space_panel),
        .save_we        (save_we),
        .save_addr      (save_addr),
        .save_data      (save_data),
        .pc_load_en     (pc_load_en),
        .pc_load_val    (pc_load_val),
        .run_ctl_valid  (run_ctl_valid),
        .run_ctl_value  (run_ctl_value),
        .panel_mode     (panel_mode),
        .irq_block      (irq_block),
        .entry_code     (entry_code)
    );

    // R8: no new save step while already executing panel code
    a_r8_no_reentry: assert property (@(posedge clk) disable iff (!rst_n)
        panel_mode |=> !save_we);
endmodule

// File: tb/tb_pcp_ctrl.sv
module tb_pcp_ctrl;
    localparam int AW = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] cpu_pc = 12'o0100;
    logic          cpu_running = 1'b0;
    logic          instr_done = 1'b0, instr_is_ion = 1'b0, instr_is_jmpi0 = 1'b0;
    logic          req_halt = 1'b0, req_trap = 1'b0, req_device = 1'b0, cause_clr = 1'b0;
    logic          space_panel, save_we, pc_load_en, run_ctl_valid, run_ctl_value;
    logic          panel_mode, irq_block;
    logic [AW-1:0] save_addr, save_data, pc_load_val;
    logic [3:0]    cause_q;
    logic [1:0]    entry_code;

    int total = 0;
    int bad = 0;
    logic [15:0] exp_q[$];

    always #5 clk = ~clk;

    pcp_ctrl #(.AW(AW)) dut (.*);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic retire(input logic ion, input logic jmp);
        instr_done = 1'b1; instr_is_ion = ion; instr_is_jmpi0 = jmp;
        tick(1);
        instr_done = 1'b0; instr_is_ion = 1'b0; instr_is_jmpi0 = 1'b0;
    endtask

    // driver side: expected entry and exit events
    task automatic expect_entry(input logic [AW-1:0] pc);
        exp_q.push_back({4'h1, pc});
        exp_q.push_back({4'h2, 12'o7777});
    endtask

    task automatic expect_exit(input logic run);
        exp_q.push_back({4'h3, 11'b0, run});
    endtask

    // monitor: turns strobes into events and compares them with the queue
    always @(negedge clk) begin
        if (rst_n) begin
            logic [15:0] ev;
            logic        seen;
            seen = 1'b1;
            if (save_we)
                ev = {(save_addr == '0) ? 4'h1 : 4'h5, save_data};      // R3
            else if (pc_load_en)
                ev = {(run_ctl_valid && run_ctl_value) ? 4'h2 : 4'h6, pc_load_val}; // R3
            else if (run_ctl_valid)
                ev = {space_panel ? 4'h7 : 4'h3, 11'b0, run_ctl_value}; // R6, R4
            else begin
                seen = 1'b0;
                ev = '0;
            end
            if (seen) begin
                if (exp_q.size() == 0) chk("R8 unexpected event", 32'(ev), 32'hFFFF);
                else chk("R3/R6 event", 32'(ev), 32'(exp_q.pop_front()));
            end
        end
    end

    initial begin
        #2000000;
        bad++;
        $display("FAIL watchdog act=timeout exp=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        tick(2);
        chk("R10 cause at reset", 32'(cause_q), 32'h1);
        chk("R10 panel at reset", 32'(panel_mode), 32'h0);
        chk("R10 save_we at reset", 32'(save_we), 32'h0);

        // R1, R2: power-on entry while halted
        expect_entry(12'o0100);
        rst_n = 1'b1;
        tick(4);
        chk("R1 panel after power-on", 32'(panel_mode), 32'h1);
        chk("R1 entry code", 32'(entry_code), 32'h0);
        chk("R5 irq_block", 32'(irq_block), 32'h1);
        chk("R4 space panel", 32'(space_panel), 32'h1);

        // R7: read-and-clear
        cause_clr = 1'b1; tick(1); cause_clr = 1'b0;
        chk("R7 clear", 32'(cause_q), 32'h0);

        // R6: exit restores halted state
        cpu_running = 1'b1;
        expect_exit(1'b0);
        retire(1'b1, 1'b0);
        retire(1'b0, 1'b1);
        tick(1);
        chk("R6 back to main", 32'(panel_mode), 32'h0);
        chk("R4 main space", 32'(space_panel), 32'h0);

        // R2: running without a boundary does not enter
        cpu_pc = 12'o1234;
        req_device = 1'b1; tick(1); req_device = 1'b0;
        tick(3);
        chk("R2 no entry without boundary", 32'(panel_mode), 32'h0);
        expect_entry(12'o1234);
        retire(1'b0, 1'b0);
        tick(3);
        chk("R2 entry at boundary", 32'(panel_mode), 32'h1);
        chk("R9 device code", 32'(entry_code), 32'h3);
        chk("R7 device bit", 32'(cause_q), 32'h8);

        // R8: trap inside panel mode is held
        req_trap = 1'b1; tick(1); req_trap = 1'b0;
        tick(3);
        chk("R8 stays in panel", 32'(panel_mode), 32'h1);
        chk("R7 sticky plus trap", 32'(cause_q), 32'hC);

        // R6: broken sequence does not exit
        retire(1'b1, 1'b0);
        retire(1'b0, 1'b0);
        retire(1'b0, 1'b1);
        tick(2);
        chk("R6 broken sequence", 32'(panel_mode), 32'h1);

        // R6 exit, then R8 deferred trap entry
        expect_exit(1'b1);
        retire(1'b1, 1'b0);
        retire(1'b0, 1'b1);
        tick(1);
        chk("R6 exit done", 32'(panel_mode), 32'h0);
        cpu_pc = 12'o2000;
        expect_entry(12'o2000);
        retire(1'b0, 1'b0);
        tick(3);
        chk("R8 deferred entry", 32'(panel_mode), 32'h1);
        chk("R9 trap code", 32'(entry_code), 32'h2);

        // R9: simultaneous halt and device while halted
        cause_clr = 1'b1; tick(1); cause_clr = 1'b0;
        expect_exit(1'b1);
        retire(1'b1, 1'b0);
        retire(1'b0, 1'b1);
        tick(2);
        cpu_pc = 12'o3000;
        cpu_running = 1'b0;
        expect_entry(12'o3000);
        req_halt = 1'b1; req_device = 1'b1; tick(1);
        req_halt = 1'b0; req_device = 1'b0;
        tick(3);
        chk("R9 halt beats device", 32'(entry_code), 32'h1);
        chk("R7 halt and device bits", 32'(cause_q), 32'hA);

        // R7: set wins over simultaneous clear
        cause_clr = 1'b1; req_trap = 1'b1; tick(1);
        cause_clr = 1'b0; req_trap = 1'b0;
        chk("R7 set wins", 32'(cause_q), 32'h4);

        tick(2);
        chk("R3 all events seen", 32'(exp_q.size()), 32'h0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule